// File: doc/BRIEF.md
# Row-Change Precharge Controller

This controller sits in front of a paged 256K x 16 memory array. It decides when the open row has to be closed and precharged before the next access can be served. It samples an active-low chip enable, a write flag and an 18-bit word address on every clock. The upper 16 address bits select a row and the lower 2 bits select a word within that row.

A precharge starts in two cases: when chip enable goes inactive, or when the row part of the address changes while the chip is enabled. A change in the word bits alone is served from the open row without a row cycle. After a precharge, the controller latches the newest address and runs a row-open phase. It then reports that the row is ready, which means read data is valid.

All times are counted in clock cycles and set by parameters:

- the minimum precharge time,
- the access time,
- the shortest spacing between row openings, with separate values for read and write openings.

Top module: `row_prechg_ctrl`

## Requirements
- R1: While reset is high, and on the cycle after it, busy, row_ready and prechg are low and open_row and open_col are zero. No row is then open, so the first enabled access enters the row-open phase on the next clock edge, with no precharge first.
- R2: While the row is ready and enabled, a change in addr[1:0] alone causes no precharge. row_ready stays high and open_col follows addr[1:0] on the next edge.
- R3: While enabled, a change in addr[17:2] during the ready state or during the row-open phase makes prechg and busy high on the next edge.
- R4: ce_n going high (inactive) while a row is open or opening makes prechg high on the next edge.
- R5: prechg stays high for at least T_PC cycles, even if ce_n returns low earlier.
- R6: A row-address change during a precharge does not start a second precharge. The row latched into open_row when the row-open phase begins is the address present at that moment.
- R7: The row-open phase (busy high, prechg low) lasts T_AA cycles. It is then followed by row_ready high and busy low.
- R8: Two starts of the row-open phase are at least T_RC cycles apart when the earlier one was a read (we=0), and at least T_WC cycles apart when it was a write (we=1). During the wait, prechg stays high.
- R9: A precharge that ends with ce_n high returns to idle, with all three status outputs low. While idle with ce_n high, address changes leave open_row and open_col unchanged.
- R10: row_ready is never high together with busy, and prechg is never high without busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we | input | 1 | Write flag, sampled when a row opens, selects the cycle-time limit |
| addr | input | ADDR_W (18) | Word address; bits [17:2] row, bits [1:0] word in row |
| busy | output | 1 | High during precharge and row-open phase |
| row_ready | output | 1 | Row open and data valid |
| prechg | output | 1 | Precharge in progress |
| open_row | output | ADDR_W-COL_W (16) | Row latched at the last row opening |
| open_col | output | COL_W (2) | Word index currently selected |

## Verification
The main sequencing is driven with these address patterns:

- word-only changes, which separate a correct row comparison from one that includes the column bits;
- a row change while ready and while still opening, which exposes a missing change detection in either state;
- a second row change inside a precharge, which shows whether the newest address is latched and whether a second precharge is avoided.

Chip enable is also dropped and then re-asserted early, which separates a precharge that respects its minimum time from one that cuts it short. A row change during a write opening, placed against one during a read opening, tells the T_WC spacing apart from T_RC. A final disable leads back to idle, and a mid-run reset is followed by an immediate access to confirm the straight-to-open path.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_READY = 2'd2,
    ST_PRE   = 2'd3
  } rpc_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rpc_row_cmp.sv
module rpc_row_cmp #(
  parameter int ADDR_W = 18,
  parameter int COL_W  = 2,
  localparam int ROW_W = ADDR_W - COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ROW_W-1:0]  cur_row,
  output logic              row_hit,
  output logic [ROW_W-1:0]  addr_row,
  output logic [COL_W-1:0]  addr_col
);
  // Only the row field takes part in the comparison.
  assign addr_row = addr[ADDR_W-1:COL_W];
  assign addr_col = addr[COL_W-1:0];
  assign row_hit  = (addr_row == cur_row);
endmodule

// File: rtl/rpc_timer.sv
module rpc_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/rpc_seq.sv
module rpc_seq
  import rpc_pkg::*;
#(
  parameter int T_PC = 3,
  parameter int T_AA = 2,
  parameter int T_RC = 6,
  parameter int T_WC = 5,
  localparam int PW  = cnt_bits(max2(T_PC, T_AA)),
  localparam int CW  = cnt_bits(max2(T_RC, T_WC))
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       we,
  input  logic       row_hit,
  input  logic       ph_zero,
  input  logic       rc_zero,
  output rpc_state_e state_d,
  output logic       ph_load,
  output logic [PW-1:0] ph_val,
  output logic       rc_load,
  output logic [CW-1:0] rc_val,
  output logic       latch_row
);
  localparam logic [PW-1:0] PH_PC = PW'(T_PC - 1);
  localparam logic [PW-1:0] PH_AA = PW'(T_AA - 1);
  localparam logic [CW-1:0] RC_RD = CW'(T_RC - 1);
  localparam logic [CW-1:0] RC_WR = CW'(T_WC - 1);

  rpc_state_e state_q;

  always_comb begin
    state_d   = state_q;
    ph_load   = 1'b0;
    ph_val    = PH_AA;
    rc_load   = 1'b0;
    rc_val    = we ? RC_WR : RC_RD;
    latch_row = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (en && rc_zero) begin
          state_d   = ST_OPEN;
          ph_load   = 1'b1;
          rc_load   = 1'b1;
          latch_row = 1'b1;
        end
      end
      ST_OPEN: begin
        if (!en || !row_hit) begin
          state_d = ST_PRE;
          ph_load = 1'b1;
          ph_val  = PH_PC;
        end else if (ph_zero) begin
          state_d = ST_READY;
        end
      end
      ST_READY: begin
        if (!en || !row_hit) begin
          state_d = ST_PRE;
          ph_load = 1'b1;
          ph_val  = PH_PC;
        end
      end
      ST_PRE: begin
        if (ph_zero) begin
          if (!en) begin
            state_d = ST_IDLE;
          end else if (rc_zero) begin
            state_d   = ST_OPEN;
            ph_load   = 1'b1;
            rc_load   = 1'b1;
            latch_row = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/row_prechg_ctrl.sv
module row_prechg_ctrl
  import rpc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int COL_W  = 2,
  parameter int T_PC   = 3,
  parameter int T_AA   = 2,
  parameter int T_RC   = 6,
  parameter int T_WC   = 5,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int PW    = cnt_bits(max2(T_PC, T_AA)),
  localparam int CW    = cnt_bits(max2(T_RC, T_WC))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              row_ready,
  output logic              prechg,
  output logic [ROW_W-1:0]  open_row,
  output logic [COL_W-1:0]  open_col
);
  logic             en;
  logic             row_hit;
  logic [ROW_W-1:0] a_row;
  logic [COL_W-1:0] a_col;
  logic             ph_zero, rc_zero;
  logic             ph_load, rc_load, latch_row;
  logic [PW-1:0]    ph_val;
  logic [CW-1:0]    rc_val;
  rpc_state_e       state_d;

  assign en = ~ce_n;

  rpc_row_cmp #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_cmp (
    .addr(addr), .cur_row(open_row), .row_hit(row_hit),
    .addr_row(a_row), .addr_col(a_col)
  );

  rpc_timer #(.W(PW)) u_ph_tmr (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  rpc_timer #(.W(CW)) u_rc_tmr (
    .clk(clk), .rst(rst), .load(rc_load), .load_val(rc_val), .zero(rc_zero)
  );

  rpc_seq #(.T_PC(T_PC), .T_AA(T_AA), .T_RC(T_RC), .T_WC(T_WC)) u_seq (
    .clk(clk), .rst(rst), .en(en), .we(we), .row_hit(row_hit),
    .ph_zero(ph_zero), .rc_zero(rc_zero), .state_d(state_d),
    .ph_load(ph_load), .ph_val(ph_val), .rc_load(rc_load),
    .rc_val(rc_val), .latch_row(latch_row)
  );

  // Registered outputs follow the next-state decode.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      row_ready <= 1'b0;
      prechg    <= 1'b0;
      open_row  <= '0;
      open_col  <= '0;
    end else begin
      busy      <= (state_d == ST_OPEN) || (state_d == ST_PRE);
      row_ready <= (state_d == ST_READY);
      prechg    <= (state_d == ST_PRE);
      if (latch_row) open_row <= a_row;
      if (en && ((state_d == ST_OPEN) || (state_d == ST_READY)))
        open_col <= a_col;
    end
  end
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
  parameter int ADDR_W = 18,
  parameter int COL_W  = 2,
  parameter int T_PC   = 3,
  parameter int T_AA   = 2,
  localparam int ROW_W = ADDR_W - COL_W
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              row_ready,
  input logic              prechg,
  input logic [ROW_W-1:0]  open_row
);
  logic [15:0] pre_cnt, opn_cnt;
  logic        opening;

  assign opening = busy && !prechg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      opn_cnt <= '0;
    end else begin
      pre_cnt <= prechg  ? pre_cnt + 16'd1 : 16'd0;
      opn_cnt <= opening ? opn_cnt + 16'd1 : 16'd0;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy && !row_ready && !prechg));

  p_col_only_r2: assert property (@(posedge clk) disable iff (rst)
    (row_ready && !ce_n && addr[ADDR_W-1:COL_W] == open_row) |=> (row_ready && !prechg));

  p_row_change_r3: assert property (@(posedge clk) disable iff (rst)
    (row_ready && !ce_n && addr[ADDR_W-1:COL_W] != open_row) |=> prechg);

  p_ce_off_r4: assert property (@(posedge clk) disable iff (rst)
    (row_ready && ce_n) |=> prechg);

  p_pre_min_r5: assert property (@(posedge clk) disable iff (rst)
    (pre_cnt != 16'd0 && !prechg) |-> (pre_cnt >= 16'(T_PC)));

  p_open_len_r7: assert property (@(posedge clk) disable iff (rst)
    (opn_cnt != 16'd0 && row_ready) |-> (opn_cnt == 16'(T_AA)));

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(row_ready && busy) && (!prechg || busy));
endmodule

bind row_prechg_ctrl rpc_checker #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .T_PC(T_PC), .T_AA(T_AA)
) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .addr(addr), .busy(busy),
  .row_ready(row_ready), .prechg(prechg), .open_row(open_row)
);

// File: tb/row_prechg_ctrl_tb.sv
module row_prechg_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 39;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1;
  logic        we = 1'b0;
  logic [17:0] addr = '0;
  logic        busy, row_ready, prechg;
  logic [15:0] open_row;
  logic [1:0]  open_col;
  int          checks = 0;
  int          failures = 0;

  always #(CLK_P/2) clk = ~clk;

  row_prechg_ctrl u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we(we), .addr(addr),
    .busy(busy), .row_ready(row_ready), .prechg(prechg),
    .open_row(open_row), .open_col(open_col)
  );

  // {ce_n, we, addr, busy, ready, prechg, row, col}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0,1'b0,18'h00100,3'b100,16'h0040,2'd0},
    {1'b0,1'b0,18'h00100,3'b100,16'h0040,2'd0},
    {1'b0,1'b0,18'h00100,3'b010,16'h0040,2'd0},
    {1'b0,1'b0,18'h00103,3'b010,16'h0040,2'd3},
    {1'b0,1'b0,18'h00104,3'b101,16'h0040,2'd3},
    {1'b0,1'b0,18'h00200,3'b101,16'h0040,2'd3},
    {1'b0,1'b0,18'h00200,3'b101,16'h0040,2'd3},
    {1'b0,1'b0,18'h00200,3'b100,16'h0080,2'd0},
    {1'b0,1'b0,18'h00200,3'b100,16'h0080,2'd0},
    {1'b0,1'b0,18'h00200,3'b010,16'h0080,2'd0},
    {1'b1,1'b0,18'h00200,3'b101,16'h0080,2'd0},
    {1'b0,1'b0,18'h00200,3'b101,16'h0080,2'd0},
    {1'b0,1'b0,18'h00200,3'b101,16'h0080,2'd0},
    {1'b0,1'b0,18'h00200,3'b100,16'h0080,2'd0},
    {1'b0,1'b0,18'h00300,3'b101,16'h0080,2'd0},
    {1'b0,1'b0,18'h00300,3'b101,16'h0080,2'd0},
    {1'b0,1'b0,18'h00300,3'b101,16'h0080,2'd0},
    {1'b0,1'b0,18'h00300,3'b101,16'h0080,2'd0},
    {1'b0,1'b0,18'h00300,3'b101,16'h0080,2'd0},
    {1'b0,1'b1,18'h00300,3'b100,16'h00C0,2'd0},
    {1'b0,1'b1,18'h00300,3'b100,16'h00C0,2'd0},
    {1'b0,1'b1,18'h00300,3'b010,16'h00C0,2'd0},
    {1'b0,1'b1,18'h00400,3'b101,16'h00C0,2'd0},
    {1'b0,1'b1,18'h00400,3'b101,16'h00C0,2'd0},
    {1'b0,1'b1,18'h00400,3'b101,16'h00C0,2'd0},
    {1'b0,1'b1,18'h00400,3'b100,16'h0100,2'd0},
    {1'b0,1'b1,18'h00500,3'b101,16'h0100,2'd0},
    {1'b0,1'b1,18'h00500,3'b101,16'h0100,2'd0},
    {1'b0,1'b1,18'h00500,3'b101,16'h0100,2'd0},
    {1'b0,1'b1,18'h00500,3'b101,16'h0100,2'd0},
    {1'b0,1'b1,18'h00500,3'b100,16'h0140,2'd0},
    {1'b0,1'b1,18'h00500,3'b100,16'h0140,2'd0},
    {1'b0,1'b1,18'h00500,3'b010,16'h0140,2'd0},
    {1'b1,1'b0,18'h00500,3'b101,16'h0140,2'd0},
    {1'b1,1'b0,18'h00500,3'b101,16'h0140,2'd0},
    {1'b1,1'b0,18'h00500,3'b101,16'h0140,2'd0},
    {1'b1,1'b0,18'h00500,3'b000,16'h0140,2'd0},
    {1'b1,1'b0,18'h3FFFF,3'b000,16'h0140,2'd0},
    {1'b0,1'b0,18'h00140,3'b100,16'h0050,2'd0}
  };

  function automatic string tag_of(input int i);
    if (i <= 2)  return "R7";
    if (i == 3)  return "R2";
    if (i == 4)  return "R3";
    if (i <= 7)  return "R6";
    if (i <= 9)  return "R7";
    if (i == 10) return "R4";
    if (i <= 13) return "R5";
    if (i <= 18) return "R8";
    if (i <= 24) return "R3";
    if (i <= 30) return "R8";
    if (i <= 32) return "R7";
    if (i <= 35) return "R4";
    if (i <= 37) return "R9";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [20:0] exp);
    logic [20:0] act;
    act = {busy, row_ready, prechg, open_row, open_col};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h (busy,ready,prechg,row,col)", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    checks++;
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 reset", {3'b000, 16'h0000, 2'd0});
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ce_n = VEC[i][40];
      we   = VEC[i][39];
      addr = VEC[i][38:21];
      @(posedge clk);
      #1 chk(tag_of(i), VEC[i][20:0]);
      checks++;
      if (row_ready && busy) begin
        failures++;
        $display("FAIL R10 act=ready&busy exp=exclusive");
      end
    end

    // Reach ready, then reset mid-run.
    repeat (2) @(posedge clk);
    #1 chk("R7 ready again", {3'b010, 16'h0050, 2'd0});
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1 chk("R1 mid reset", {3'b000, 16'h0000, 2'd0});
    @(negedge clk);
    rst  = 1'b0;
    ce_n = 1'b0;
    addr = 18'h00009;
    @(posedge clk);
    #1 chk("R1 first open", {3'b100, 16'h0002, 2'd1});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule